// File: doc/BRIEF.md
# Two-Bank SDRAM Command Issuer

This block turns single-word requests (mode load, row open, column read, column write, row close, refresh, burst termination, self-refresh enter and leave) into pin-level commands for a two-bank single-data-rate SDRAM. It drives the clock enable, the four command strobes, the bank select and the address bus. Every pin is driven from a register, so a request the block accepts appears on the pins in the next cycle.

The block keeps a small model of the device. For each bank it records whether a row is open and whether a recovery count is still running after an automatic close. It also records whether a burst with automatic close is still in flight, whether a mode-load quiet gap is running, and whether the device is in self refresh. A request is accepted only when it is legal in that state. A request that is not legal stalls: `req_ready` stays low, the pins show a no-operation, and `cmd_err` pulses once.

The burst length, the recovery count, the mode-load gap and the bus widths are parameters.

Top module: `sdram_cmd_issuer`

## Requirements
- R1: During reset and in the first cycle after it, the pins show CKE high with the no-operation strobes (CS# low, RAS#, CAS# and WE# high), BA and the address are zero, and `cmd_err` is low.
- R2: `req_cmd` codes are mode-load 0, open 1, read 2, write 3, close 4, refresh 5, burst stop 6, self-refresh enter 7 and self-refresh leave 8. An accepted request shows up on the pins in the next cycle with CKE high, as CS#,RAS#,CAS#,WE# = mode-load LLLL, refresh LLLH, open LLHH, read LHLH, write LHLL, burst stop LHHL, close LLHL. In any cycle that follows no acceptance, the pins show LHHL's neighbour code LHHH (no-operation).
- R3: For mode-load and open, BA equals `req_bank` and the address equals `req_addr`. For read and write, BA equals `req_bank`, the low COL_W address bits carry `req_col`, bit AP_BIT (A10) carries `req_flag` (automatic close), and the other bits are zero. For close, bit AP_BIT carries `req_flag`, BA equals `req_bank`, and the other bits are zero. Refresh, burst stop and self-refresh commands drive BA and the address to zero.
- R4: A valid request that is refused leaves `req_ready` low and no command on the pins. `cmd_err` goes high for exactly one cycle, in the cycle after the first refused cycle, and does not pulse again while the refusal continues on consecutive cycles.
- R5: Mode-load, refresh and self-refresh enter are accepted only when both banks are closed and neither bank has a recovery count running.
- R6: After a mode-load is accepted, no request is accepted for the next MRD_CYC-1 cycles.
- R7: Open is accepted only for a closed bank with no recovery count running. Read and write are accepted only for an open bank.
- R8: For BURST_LEN cycles after a read or write with automatic close is accepted, no read or write to either bank is accepted, and a close that covers that bank is refused. The bank is then closed, and an open to it is first accepted BURST_LEN+TRP_CYC+1 cycles after the acceptance of the read or write.
- R9: A close with `req_flag` high closes both banks and ignores `req_bank`. With `req_flag` low it closes only the bank chosen by `req_bank` (0 = bank A, 1 = bank B). A close of a bank that is already closed is accepted.
- R10: Burst stop is accepted in every state except self refresh and the mode-load gap. When it is accepted during an automatic-close burst, that burst ends at once: the bank closes and its recovery count starts.
- R11: Self-refresh enter puts CKE low with the refresh strobes (LLLH). While in self refresh, CKE stays low, the strobes show no-operation, and only self-refresh leave is accepted. Leave drives CKE high with no-operation. Outside self refresh, leave is refused.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request is legal now and is taken when valid |
| req_cmd | input | 4 | Request code (see R2) |
| req_bank | input | 1 | Target bank, 0 = A, 1 = B |
| req_addr | input | ADDR_W | Row address for open, opcode for mode-load |
| req_col | input | COL_W | Column for read and write |
| req_flag | input | 1 | Automatic close for read/write, both banks for close |
| sd_cke | output | 1 | Clock enable pin |
| sd_cs_n | output | 1 | Chip select, active low |
| sd_ras_n | output | 1 | Row strobe, active low |
| sd_cas_n | output | 1 | Column strobe, active low |
| sd_we_n | output | 1 | Write enable, active low |
| sd_ba | output | 1 | Bank select pin |
| sd_addr | output | ADDR_W | Address pins, A10 at AP_BIT |
| cmd_err | output | 1 | One-cycle pulse on a newly refused request |

## Verification
The bench builds the block with its defaults: a burst length of 4, a recovery count of 3 and a mode-load gap of 2. With a burst of 4, a write held against an automatic-close burst on the other bank stalls for several cycles, so the single-pulse error rule is exercised over a long refusal. The short recovery count lets an open to the just-closed bank be retried until it is accepted, which pins down the exact acceptance cycle. Burst stop is issued in the middle of a 4-beat automatic-close burst, so the early end of that burst can be seen.

// File: rtl/sdcmd_pkg.sv
package sdcmd_pkg;

    typedef enum logic [3:0] {
        OP_MODE = 4'd0,
        OP_ACT  = 4'd1,
        OP_RD   = 4'd2,
        OP_WR   = 4'd3,
        OP_PRE  = 4'd4,
        OP_REF  = 4'd5,
        OP_BST  = 4'd6,
        OP_SRE  = 4'd7,
        OP_SRX  = 4'd8
    } op_e;

    typedef struct packed {
        logic cke;
        logic cs_n;
        logic ras_n;
        logic cas_n;
        logic we_n;
    } ctl_t;

    localparam ctl_t CTL_NOP = '{cke: 1'b1, cs_n: 1'b0, ras_n: 1'b1, cas_n: 1'b1, we_n: 1'b1};

    function automatic ctl_t ctl_of(op_e op);
        ctl_t c;
        c = CTL_NOP;
        case (op)
            OP_MODE: c = '{1'b1, 1'b0, 1'b0, 1'b0, 1'b0};
            OP_REF:  c = '{1'b1, 1'b0, 1'b0, 1'b0, 1'b1};
            OP_ACT:  c = '{1'b1, 1'b0, 1'b0, 1'b1, 1'b1};
            OP_RD:   c = '{1'b1, 1'b0, 1'b1, 1'b0, 1'b1};
            OP_WR:   c = '{1'b1, 1'b0, 1'b1, 1'b0, 1'b0};
            OP_BST:  c = '{1'b1, 1'b0, 1'b1, 1'b1, 1'b0};
            OP_PRE:  c = '{1'b1, 1'b0, 1'b0, 1'b1, 1'b0};
            OP_SRE:  c = '{1'b0, 1'b0, 1'b0, 1'b0, 1'b1};
            default: c = CTL_NOP;
        endcase
        return c;
    endfunction

    function automatic logic is_column(op_e op);
        return (op == OP_RD) || (op == OP_WR);
    endfunction

endpackage

// File: rtl/sd_bank_state.sv
module sd_bank_state #(
    parameter int TRP_CYC = 3
) (
    input  logic clk,
    input  logic rst,
    input  logic open_i,
    input  logic close_i,
    input  logic ap_close_i,
    output logic active_o,
    output logic recover_o
);
    localparam int TRP_W = $clog2(TRP_CYC + 1);

    logic [TRP_W-1:0] trp_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            active_o <= 1'b0;
            trp_q    <= '0;
        end else begin
            if (trp_q != '0)
                trp_q <= trp_q - TRP_W'(1);
            if (open_i)
                active_o <= 1'b1;
            if (close_i)
                active_o <= 1'b0;
            if (ap_close_i) begin
                active_o <= 1'b0;
                trp_q    <= TRP_W'(TRP_CYC);
            end
        end
    end

    assign recover_o = (trp_q != '0);

endmodule

// File: rtl/sd_ap_tracker.sv
module sd_ap_tracker #(
    parameter int BURST_LEN = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic start_i,
    input  logic bank_i,
    input  logic stop_i,
    output logic busy_o,
    output logic bank_o,
    output logic done_o
);
    localparam int CNT_W = (BURST_LEN > 1) ? $clog2(BURST_LEN) : 1;

    logic [CNT_W-1:0] cnt_q;

    assign done_o = busy_o && ((cnt_q == '0) || stop_i);

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_o <= 1'b0;
            bank_o <= 1'b0;
            cnt_q  <= '0;
        end else if (start_i) begin
            busy_o <= 1'b1;
            bank_o <= bank_i;
            cnt_q  <= CNT_W'(BURST_LEN - 1);
        end else if (done_o) begin
            busy_o <= 1'b0;
        end else if (busy_o) begin
            cnt_q <= cnt_q - CNT_W'(1);
        end
    end

endmodule

// File: rtl/sdram_cmd_issuer.sv
module sdram_cmd_issuer
    import sdcmd_pkg::*;
#(
    parameter int ADDR_W    = 11,
    parameter int AP_BIT    = 10,
    parameter int COL_W     = 8,
    parameter int BURST_LEN = 4,
    parameter int TRP_CYC   = 3,
    parameter int MRD_CYC   = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [3:0]        req_cmd,
    input  logic              req_bank,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [COL_W-1:0]  req_col,
    input  logic              req_flag,
    output logic              sd_cke,
    output logic              sd_cs_n,
    output logic              sd_ras_n,
    output logic              sd_cas_n,
    output logic              sd_we_n,
    output logic              sd_ba,
    output logic [ADDR_W-1:0] sd_addr,
    output logic              cmd_err
);
    localparam int NBANK = 2;
    localparam int GAP_W = (MRD_CYC > 1) ? $clog2(MRD_CYC) : 1;

    op_e              op;
    logic             legal, accept;
    logic [NBANK-1:0] bank_open, bank_rec;
    logic             ap_busy, ap_bank, ap_done;
    logic             in_sr, refused_q;
    logic [GAP_W-1:0] gap_q;
    logic             all_idle;
    logic [ADDR_W-1:0] addr_nx;
    logic             ba_nx;
    ctl_t             ctl_q;

    assign op     = op_e'(req_cmd);
    assign accept = req_valid && legal;
    assign req_ready = legal;
    assign all_idle  = (bank_open == '0) && (bank_rec == '0);

    // per-bank open/recovery state
    for (genvar b = 0; b < NBANK; b++) begin : g_bank
        sd_bank_state #(.TRP_CYC(TRP_CYC)) u_bank (
            .clk        (clk),
            .rst        (rst),
            .open_i     (accept && op == OP_ACT && req_bank == 1'(b)),
            .close_i    (accept && op == OP_PRE && (req_flag || req_bank == 1'(b))),
            .ap_close_i (ap_done && ap_bank == 1'(b)),
            .active_o   (bank_open[b]),
            .recover_o  (bank_rec[b])
        );
    end

    sd_ap_tracker #(.BURST_LEN(BURST_LEN)) u_ap (
        .clk     (clk),
        .rst     (rst),
        .start_i (accept && is_column(op) && req_flag),
        .bank_i  (req_bank),
        .stop_i  (accept && op == OP_BST),
        .busy_o  (ap_busy),
        .bank_o  (ap_bank),
        .done_o  (ap_done)
    );

    // legality of the presented request in the current state
    always_comb begin
        legal = 1'b0;
        if (in_sr) begin
            legal = (op == OP_SRX);
        end else if (gap_q == '0) begin
            case (op)
                OP_MODE, OP_REF, OP_SRE: legal = all_idle;
                OP_ACT:  legal = !bank_open[req_bank] && !bank_rec[req_bank];
                OP_RD, OP_WR: legal = bank_open[req_bank] && !ap_busy;
                OP_PRE:  legal = !(ap_busy && (req_flag || ap_bank == req_bank));
                OP_BST:  legal = 1'b1;
                default: legal = 1'b0;
            endcase
        end
    end

    // address and bank pins for the accepted request
    always_comb begin
        addr_nx = '0;
        ba_nx   = 1'b0;
        case (op)
            OP_MODE, OP_ACT: begin
                addr_nx = req_addr;
                ba_nx   = req_bank;
            end
            OP_RD, OP_WR: begin
                addr_nx[COL_W-1:0] = req_col;
                addr_nx[AP_BIT]    = req_flag;
                ba_nx              = req_bank;
            end
            OP_PRE: begin
                addr_nx[AP_BIT] = req_flag;
                ba_nx           = req_bank;
            end
            default: begin
                addr_nx = '0;
                ba_nx   = 1'b0;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            in_sr     <= 1'b0;
            gap_q     <= '0;
            refused_q <= 1'b0;
            cmd_err   <= 1'b0;
            ctl_q     <= CTL_NOP;
            sd_ba     <= 1'b0;
            sd_addr   <= '0;
        end else begin
            refused_q <= req_valid && !legal;
            cmd_err   <= req_valid && !legal && !refused_q;

            if (accept && op == OP_MODE)
                gap_q <= GAP_W'(MRD_CYC - 1);
            else if (gap_q != '0)
                gap_q <= gap_q - GAP_W'(1);

            if (accept && op == OP_SRE)
                in_sr <= 1'b1;
            else if (accept && op == OP_SRX)
                in_sr <= 1'b0;

            if (accept) begin
                ctl_q   <= ctl_of(op);
                sd_ba   <= ba_nx;
                sd_addr <= addr_nx;
            end else begin
                ctl_q     <= CTL_NOP;
                ctl_q.cke <= !in_sr;
                sd_ba     <= 1'b0;
                sd_addr   <= '0;
            end
        end
    end

    assign sd_cke   = ctl_q.cke;
    assign sd_cs_n  = ctl_q.cs_n;
    assign sd_ras_n = ctl_q.ras_n;
    assign sd_cas_n = ctl_q.cas_n;
    assign sd_we_n  = ctl_q.we_n;

endmodule

// File: rtl/sdram_cmd_issuer_chk.sv
module sdram_cmd_issuer_chk
    import sdcmd_pkg::*;
(
    input logic       clk,
    input logic       rst,
    input logic       req_valid,
    input logic       req_ready,
    input logic [3:0] req_cmd,
    input logic       req_flag,
    input logic       sd_cke,
    input logic       sd_cs_n,
    input logic       sd_ras_n,
    input logic       sd_cas_n,
    input logic       sd_we_n,
    input logic       cmd_err
);
    logic acc;
    assign acc = req_valid && req_ready;

    // R1
    a_r1_reset_nop: assert property (@(posedge clk)
        rst |=> (sd_cke && !sd_cs_n && sd_ras_n && sd_cas_n && sd_we_n && !cmd_err));

    // R4
    a_r4_err_single: assert property (@(posedge clk) disable iff (rst)
        cmd_err |=> !cmd_err);

    // R4
    a_r4_refused_nop: assert property (@(posedge clk) disable iff (rst)
        !acc |=> (sd_ras_n && sd_cas_n && sd_we_n));

    // R6 (holds for a gap of two or more cycles)
    a_r6_mode_gap: assert property (@(posedge clk) disable iff (rst)
        (acc && req_cmd == OP_MODE) |=> !req_ready);

    // R8
    a_r8_ap_block: assert property (@(posedge clk) disable iff (rst)
        (acc && (req_cmd == OP_RD || req_cmd == OP_WR) && req_flag)
        |=> !(req_ready && (req_cmd == OP_RD || req_cmd == OP_WR)));

    // R11
    a_r11_sr_hold: assert property (@(posedge clk) disable iff (rst)
        (!sd_cke && !(acc && req_cmd == OP_SRX)) |=> !sd_cke);

    // R11
    a_r11_sr_only_leave: assert property (@(posedge clk) disable iff (rst)
        !sd_cke |-> !(req_ready && req_cmd != OP_SRX));

endmodule

bind sdram_cmd_issuer sdram_cmd_issuer_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .req_cmd   (req_cmd),
    .req_flag  (req_flag),
    .sd_cke    (sd_cke),
    .sd_cs_n   (sd_cs_n),
    .sd_ras_n  (sd_ras_n),
    .sd_cas_n  (sd_cas_n),
    .sd_we_n   (sd_we_n),
    .cmd_err   (cmd_err)
);

// File: tb/sdram_cmd_issuer_test.sv
module sdram_cmd_issuer_test;
    import sdcmd_pkg::*;

    localparam int ADDR_W = 11;
    localparam int COL_W  = 8;
    localparam int BL     = 4;
    localparam int TRP    = 3;
    localparam int MRD    = 2;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              req_valid = 1'b0;
    logic              req_ready;
    logic [3:0]        req_cmd = 4'd0;
    logic              req_bank = 1'b0;
    logic [ADDR_W-1:0] req_addr = '0;
    logic [COL_W-1:0]  req_col = '0;
    logic              req_flag = 1'b0;
    logic              sd_cke, sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n, sd_ba;
    logic [ADDR_W-1:0] sd_addr;
    logic              cmd_err;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    sdram_cmd_issuer #(
        .ADDR_W(ADDR_W), .AP_BIT(10), .COL_W(COL_W),
        .BURST_LEN(BL), .TRP_CYC(TRP), .MRD_CYC(MRD)
    ) uut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
        .req_cmd(req_cmd), .req_bank(req_bank), .req_addr(req_addr),
        .req_col(req_col), .req_flag(req_flag), .sd_cke(sd_cke),
        .sd_cs_n(sd_cs_n), .sd_ras_n(sd_ras_n), .sd_cas_n(sd_cas_n),
        .sd_we_n(sd_we_n), .sd_ba(sd_ba), .sd_addr(sd_addr), .cmd_err(cmd_err)
    );

    // reference model state
    int  m_open[2];
    int  m_trp[2];
    int  m_ap_left;
    int  m_ap_bank;
    int  m_gap;
    bit  m_sr;
    bit  m_refused;
    bit  last_acc;
    logic [4:0]        e_ctl;   // cke cs ras cas we
    logic              e_ba;
    logic [ADDR_W-1:0] e_addr;
    logic              e_err;

    task automatic check(string tag, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    function automatic bit m_legal(op_e op, int b, bit flag);
        if (m_sr) return op == OP_SRX;
        if (m_gap > 0) return 0;
        case (op)
            OP_MODE, OP_REF, OP_SRE:
                return m_open[0] == 0 && m_open[1] == 0 && m_trp[0] == 0 && m_trp[1] == 0;
            OP_ACT: return m_open[b] == 0 && m_trp[b] == 0;
            OP_RD, OP_WR: return m_open[b] == 1 && m_ap_left == 0;
            OP_PRE: return !(m_ap_left > 0 && (flag || m_ap_bank == b));
            OP_BST: return 1;
            default: return 0;
        endcase
    endfunction

    function automatic logic [4:0] m_strobes(op_e op);
        case (op)
            OP_MODE: return 5'b10000;
            OP_REF:  return 5'b10001;
            OP_ACT:  return 5'b10011;
            OP_RD:   return 5'b10101;
            OP_WR:   return 5'b10100;
            OP_BST:  return 5'b10110;
            OP_PRE:  return 5'b10010;
            OP_SRE:  return 5'b00001;
            default: return 5'b10111;
        endcase
    endfunction

    task automatic m_reset();
        m_open = '{0, 0};
        m_trp  = '{0, 0};
        m_ap_left = 0; m_ap_bank = 0; m_gap = 0; m_sr = 0; m_refused = 0;
        e_ctl = 5'b10111; e_ba = 0; e_addr = '0; e_err = 0;
    endtask

    // one cycle: drive, check ready, advance model, check pins
    task automatic step(string tag, bit valid, op_e op, int b, int addr, int col, bit flag);
        bit lg, acc;
        req_valid = valid; req_cmd = op; req_bank = b[0];
        req_addr = addr[ADDR_W-1:0]; req_col = col[COL_W-1:0]; req_flag = flag;
        #1;
        lg  = m_legal(op, b, flag);
        acc = valid && lg;
        check(tag, "ready", int'(req_ready), int'(lg));
        @(posedge clk);
        // expected pins
        e_err = valid && !lg && !m_refused;
        m_refused = valid && !lg;
        if (acc) begin
            e_ctl = m_strobes(op);
            e_ba = 0; e_addr = '0;
            case (op)
                OP_MODE, OP_ACT: begin e_ba = b[0]; e_addr = addr[ADDR_W-1:0]; end
                OP_RD, OP_WR: begin e_ba = b[0]; e_addr = ADDR_W'(col) | (ADDR_W'(flag) << 10); end
                OP_PRE: begin e_ba = b[0]; e_addr = ADDR_W'(flag) << 10; end
                default: ;
            endcase
        end else begin
            e_ctl = {!m_sr, 4'b0111};
            e_ba = 0; e_addr = '0;
        end
        // state advance
        for (int i = 0; i < 2; i++) if (m_trp[i] > 0) m_trp[i]--;
        if (m_gap > 0) m_gap--;
        if (m_ap_left > 0) begin
            if ((acc && op == OP_BST) || m_ap_left == 1) begin
                m_open[m_ap_bank] = 0;
                m_trp[m_ap_bank] = TRP;
                m_ap_left = 0;
            end else m_ap_left--;
        end
        if (acc) begin
            case (op)
                OP_MODE: m_gap = MRD - 1;
                OP_ACT:  m_open[b] = 1;
                OP_PRE:  begin
                    if (flag) begin m_open[0] = 0; m_open[1] = 0; end
                    else m_open[b] = 0;
                end
                OP_RD, OP_WR: if (flag) begin m_ap_left = BL; m_ap_bank = b; end
                OP_SRE: m_sr = 1;
                OP_SRX: m_sr = 0;
                default: ;
            endcase
        end
        last_acc = acc;
        @(negedge clk);
        check(tag, "strobes", int'({sd_cke, sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n}), int'(e_ctl));
        check(tag, "ba", int'(sd_ba), int'(e_ba));
        check(tag, "addr", int'(sd_addr), int'(e_addr));
        check(tag, "err", int'(cmd_err), int'(e_err));
    endtask

    task automatic issue(string tag, op_e op, int b, int addr, int col, bit flag);
        for (int n = 0; n < 40; n++) begin
            step(tag, 1, op, b, addr, col, flag);
            if (last_acc) return;
        end
        check(tag, "never accepted", 0, 1);
    endtask

    task automatic hold(string tag, int n, op_e op, int b, bit flag);
        for (int i = 0; i < n; i++) step(tag, 1, op, b, 0, 0, flag);
    endtask

    task automatic idle(string tag, int n);
        for (int i = 0; i < n; i++) step(tag, 0, OP_BST, 0, 0, 0, 0);
    endtask

    initial begin
        #(200000 * 10);
        errors++;
        $display("FAIL watchdog: actual running expected finished");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        m_reset();
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: pins during reset
        check("R1", "reset strobes", int'({sd_cke, sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n}), 'h17);
        check("R1", "reset err", int'(cmd_err), 0);
        rst = 1'b0;
        idle("R1", 2);

        // R6: mode-load gap, then refresh waits one cycle
        issue("R6", OP_MODE, 1, 'h233, 0, 0);
        issue("R6", OP_REF, 0, 0, 0, 0);

        // R3: open and column addressing
        issue("R3", OP_ACT, 0, 'h155, 0, 0);
        hold("R5", 3, OP_MODE, 0, 0);
        idle("R4", 1);
        issue("R3", OP_RD, 0, 0, 'hA5, 0);
        issue("R2", OP_WR, 0, 0, 'h3C, 0);

        // R8: automatic-close burst blocks columns, then recovery
        issue("R7", OP_ACT, 1, 'h0F0, 0, 0);
        issue("R8", OP_RD, 0, 0, 'h11, 1);
        issue("R8", OP_WR, 1, 0, 'h22, 0);
        issue("R8", OP_ACT, 0, 'h321, 0, 0);

        // R9 and R7: single-bank close, column to closed bank, open of open bank
        issue("R9", OP_PRE, 1, 0, 0, 0);
        hold("R7", 3, OP_RD, 1, 0);
        hold("R7", 2, OP_ACT, 0, 0);
        idle("R4", 1);

        // R10: burst stop cuts an automatic-close write
        issue("R10", OP_WR, 0, 0, 'h7E, 1);
        hold("R10", 1, OP_PRE, 0, 0);
        issue("R10", OP_BST, 0, 0, 0, 0);
        issue("R10", OP_ACT, 0, 'h0AA, 0, 0);

        // R9: close both, close an idle bank
        issue("R9", OP_ACT, 1, 'h011, 0, 0);
        issue("R9", OP_PRE, 1, 0, 0, 1);
        issue("R9", OP_PRE, 0, 0, 0, 0);
        hold("R9", 1, OP_RD, 1, 0);
        idle("R9", 1);

        // R5 and R11: refresh, self refresh cycle
        issue("R5", OP_REF, 0, 0, 0, 0);
        issue("R11", OP_SRE, 0, 0, 0, 0);
        hold("R11", 3, OP_ACT, 1, 0);
        idle("R11", 3);
        issue("R11", OP_SRX, 0, 0, 0, 0);
        hold("R11", 2, OP_SRX, 0, 0);
        idle("R11", 1);
        issue("R7", OP_ACT, 1, 'h3FF, 0, 0);
        issue("R10", OP_BST, 0, 0, 0, 0);
        idle("R2", 2);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule